// File: doc/BRIEF.md
# Weighted-Condition Stall Event Counter

This block is a single performance-monitoring counter that watches four stall conditions raised by a processor core. Each condition has a fixed power-of-two weight, so condition *i* is worth 2^i. A four-bit selection mask picks which conditions take part. In every enabled cycle the block adds up the weights of the selected conditions that are active.

A four-bit threshold controls what that per-cycle sum does to the count. When the threshold is zero, the counter adds the whole sum, which counts the selected conditions in OR fashion. When the threshold is nonzero, the counter adds exactly one in any cycle whose sum reaches the threshold. If the threshold is set equal to the selection mask, only cycles in which every selected condition holds are counted, which gives AND-style selection.

A write port loads any full-width value into the 48-bit count, including clearing it to zero. When the count wraps past its top value it returns to zero and sets a sticky overflow flag. The next write clears that flag.

Top module: `stall_event_counter`

## Requirements
- R1: During and right after synchronous reset (rst_n low), count_o is 0 and ovf_o is 0.
- R2: With cmask_i equal to 0 and count_en_i high, each cycle adds to count_o the sum over i of 2^i for every bit i set in both umask_i and cond_i. Bit 0 is the L2-miss-pending load, bit 1 the memory-pending load, bit 2 the no-dispatch cycle and bit 3 the L1D-miss-pending load.
- R3: A condition whose umask_i bit is 0 contributes nothing, whatever its cond_i value.
- R4: With cmask_i nonzero and count_en_i high, count_o grows by exactly 1 in a cycle whose weighted sum is greater than or equal to cmask_i, and is unchanged otherwise.
- R5: The mask/threshold pairs 0x5/5, 0x6/6 and 0xC/12 count a cycle only when both selected conditions are active together.
- R6: While count_en_i is low and no write occurs, count_o and ovf_o hold their values.
- R7: A write (wr_en_i high) sets count_o to the full 48-bit wr_data_i on the next cycle, including values of 2^31 and above. Writing zero clears the count, and the count then stays at zero while counting is disabled.
- R8: When a write and an increment fall in the same cycle, the written value is kept and that cycle's increment is dropped.
- R9: An increment that carries out of bit 47 wraps count_o modulo 2^48 and sets ovf_o. Once set, ovf_o stays set until a write.
- R10: A write clears ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_i | input | 4 | Per-cycle stall conditions, bit i weighted 2^i |
| umask_i | input | 4 | Selection mask over the conditions |
| cmask_i | input | 4 | Threshold; 0 selects sum accumulation |
| count_en_i | input | 1 | Counting enable |
| wr_en_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 48 | Value loaded by a write |
| count_o | output | 48 | Current count |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
The bench walks all sixteen condition patterns under each AND pair. A design that compared the raw sum with a greater-than, or that ORed the selections, would count cycles where only one condition holds. It also lines up a write with a full-weight increment in the same cycle, which shows whether the write really takes priority. It loads values above 2^31 to catch a 32-bit write path, and it pushes the count across the 48-bit boundary in both the sum mode and the threshold mode. A lost carry there, or an overflow flag that is not sticky or is not cleared by a write, shows up in the count or in the flag.

// File: rtl/sec_pkg.sv
// Shared definitions for the weighted-condition stall event counter.
// Assumes condition i always carries weight 2^i.
package sec_pkg;

    // How the per-cycle sum turns into a counter step
    typedef enum logic {
        STEP_SUM    = 1'b0,   // threshold zero: add the whole weighted sum
        STEP_THRESH = 1'b1    // threshold nonzero: add one if sum >= threshold
    } step_mode_e;

    // Largest weighted sum for a given number of conditions
    function automatic int max_sum(input int n);
        return (1 << n) - 1;
    endfunction

endpackage

// File: rtl/sec_weight_sum.sv
// Adds the weights of the selected, active conditions for one cycle.
// Assumes condition i has weight 2^i, so the sum fits in NUM_COND bits.
module sec_weight_sum #(
    parameter int NUM_COND = 4,
    localparam int SUM_W   = NUM_COND
) (
    input  logic [NUM_COND-1:0] cond_i,
    input  logic [NUM_COND-1:0] umask_i,
    output logic [SUM_W-1:0]    sum_o
);

    logic [SUM_W-1:0] term [NUM_COND];

    // One weighted term per condition, zero when the condition is unselected or idle
    for (genvar gi = 0; gi < NUM_COND; gi++) begin : g_term
        always_comb term[gi] = (cond_i[gi] && umask_i[gi])
                               ? SUM_W'(1 << gi) : '0;
    end

    // Reduce the terms to the per-cycle sum
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NUM_COND; i++) begin
            sum_o = sum_o + term[i];
        end
    end

endmodule

// File: rtl/sec_step_select.sv
// Turns the per-cycle weighted sum into the step the counter adds.
// A zero threshold passes the sum through. A nonzero threshold gives 1 or 0.
module sec_step_select
    import sec_pkg::*;
#(
    parameter int NUM_COND = 4,
    localparam int SUM_W   = NUM_COND
) (
    input  logic [SUM_W-1:0]    sum_i,
    input  logic [NUM_COND-1:0] cmask_i,
    output logic [SUM_W-1:0]    step_o
);

    step_mode_e mode;

    // Choose the mode from the threshold value
    always_comb mode = (cmask_i == '0) ? STEP_SUM : STEP_THRESH;

    // Form the step for this cycle
    always_comb begin
        case (mode)
            STEP_SUM:    step_o = sum_i;
            STEP_THRESH: step_o = (sum_i >= cmask_i) ? SUM_W'(1) : '0;
            default:     step_o = '0;
        endcase
    end

endmodule

// File: rtl/sec_accum.sv
// Holds the count and the sticky overflow flag.
// A write wins over an increment, and a write clears the overflow flag.
// Assumes STEP_W < CNT_W.
module sec_accum #(
    parameter int CNT_W   = 48,
    parameter int STEP_W  = 4,
    localparam int EXT_W  = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_o
);

    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic [EXT_W-1:0] next_ext;

    // Widened add so that the carry out of the top bit is kept
    always_comb next_ext = {1'b0, count_q} + {{(EXT_W-STEP_W){1'b0}}, step_i};

    // Register update: reset, then a write, then counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (wr_en_i) begin
            count_q <= wr_data_i;
            ovf_q   <= 1'b0;
        end else if (count_en_i) begin
            count_q <= next_ext[CNT_W-1:0];
            ovf_q   <= ovf_q | next_ext[CNT_W];
        end
    end

    assign count_o = count_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/stall_event_counter.sv
// Top level of the weighted-condition stall event counter.
// Assumes cond_i, umask_i and cmask_i are synchronous to clk.
module stall_event_counter #(
    parameter int NUM_COND = 4,
    parameter int CNT_W    = 48,
    localparam int SUM_W   = NUM_COND
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_i,
    input  logic [NUM_COND-1:0] umask_i,
    input  logic [NUM_COND-1:0] cmask_i,
    input  logic                count_en_i,
    input  logic                wr_en_i,
    input  logic [CNT_W-1:0]    wr_data_i,
    output logic [CNT_W-1:0]    count_o,
    output logic                ovf_o
);

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] step;

    sec_weight_sum #(.NUM_COND(NUM_COND)) u_sum (
        .cond_i  (cond_i),
        .umask_i (umask_i),
        .sum_o   (sum)
    );

    sec_step_select #(.NUM_COND(NUM_COND)) u_step (
        .sum_i   (sum),
        .cmask_i (cmask_i),
        .step_o  (step)
    );

    sec_accum #(.CNT_W(CNT_W), .STEP_W(SUM_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (count_en_i),
        .step_i     (step),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .count_o    (count_o),
        .ovf_o      (ovf_o)
    );

endmodule

// File: rtl/sec_checker.sv
// Properties for the stall event counter, bound onto every instance of the top.
module sec_checker #(
    parameter int NUM_COND = 4,
    parameter int CNT_W    = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_COND-1:0] cond_i,
    input logic [NUM_COND-1:0] umask_i,
    input logic [NUM_COND-1:0] cmask_i,
    input logic                count_en_i,
    input logic                wr_en_i,
    input logic [CNT_W-1:0]    wr_data_i,
    input logic [CNT_W-1:0]    count_o,
    input logic                ovf_o
);

    localparam int MAX_STEP = sec_pkg::max_sum(NUM_COND);

    assert_sum_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && !wr_en_i && cmask_i == '0)
        |=> ((count_o - $past(count_o)) <= CNT_W'(MAX_STEP)));

    assert_unselected_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && !wr_en_i && (cond_i & umask_i) == '0) |=> $stable(count_o));

    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && !wr_en_i && cmask_i != '0)
        |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

    assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !wr_en_i) |=> ($stable(count_o) && $stable(ovf_o)));

    assert_write_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (count_o == $past(wr_data_i)));

    assert_sticky_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !wr_en_i) |=> ovf_o);

    assert_write_clears_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> !ovf_o);

endmodule

bind stall_event_counter sec_checker #(.NUM_COND(NUM_COND), .CNT_W(CNT_W)) u_sec_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond_i),
    .umask_i    (umask_i),
    .cmask_i    (cmask_i),
    .count_en_i (count_en_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .count_o    (count_o),
    .ovf_o      (ovf_o)
);

// File: tb/test_stall_event_counter.sv
module test_stall_event_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cond, umask, cmask;
    logic        en, we;
    logic [47:0] wd;
    logic [47:0] count;
    logic        ovf;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stall_event_counter i_stall_event_counter (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .umask_i(umask), .cmask_i(cmask),
        .count_en_i(en), .wr_en_i(we), .wr_data_i(wd), .count_o(count), .ovf_o(ovf)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge; return after one rising edge has used them
    task automatic drive(input logic [3:0] c, input logic e, input logic w, input logic [47:0] d);
        cond = c; en = e; we = w; wd = d;
        @(negedge clk);
    endtask

    function automatic logic [47:0] weight_of(input logic [3:0] bits);
        logic [47:0] s = 0;
        for (int i = 0; i < 4; i++) if (bits[i]) s += 48'(1 << i);
        return s;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        drive(4'hF, 1'b1, 1'b0, 48'd0);
        drive(4'hF, 1'b1, 1'b0, 48'd0);
        chk("R1 count in reset", count, 48'd0);
        chk("R1 ovf in reset", {47'd0, ovf}, 48'd0);
        rst_n = 1'b1;
        drive(4'h0, 1'b0, 1'b0, 48'd0);
        chk("R1 count after reset", count, 48'd0);
    endtask

    task automatic t_or_accum();
        logic [3:0] pats [7] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h5, 4'hF, 4'h0};
        logic [47:0] exp = 0;
        umask = 4'hF; cmask = 4'h0;
        drive(4'h0, 1'b0, 1'b1, 48'd0);
        for (int k = 0; k < 7; k++) begin
            drive(pats[k], 1'b1, 1'b0, 48'd0);
            exp += weight_of(pats[k]);
            chk("R2 weighted sum accumulate", count, exp);
        end
    endtask

    task automatic t_masked();
        umask = 4'h5; cmask = 4'h0;
        drive(4'h0, 1'b0, 1'b1, 48'd0);
        for (int k = 0; k < 3; k++) drive(4'hA, 1'b1, 1'b0, 48'd0);
        chk("R3 unselected conditions ignored", count, 48'd0);
        drive(4'hF, 1'b1, 1'b0, 48'd0);
        chk("R3 only selected weights added", count, 48'd5);
        drive(4'h2, 1'b1, 1'b0, 48'd0);
        chk("R3 unselected bit 1 ignored", count, 48'd5);
        drive(4'h1, 1'b1, 1'b0, 48'd0);
        chk("R3 selected bit 0 added", count, 48'd6);
    endtask

    task automatic t_threshold();
        umask = 4'hF; cmask = 4'h3;
        drive(4'h0, 1'b0, 1'b1, 48'd0);
        drive(4'h1, 1'b1, 1'b0, 48'd0); chk("R4 sum 1 below 3", count, 48'd0);
        drive(4'h2, 1'b1, 1'b0, 48'd0); chk("R4 sum 2 below 3", count, 48'd0);
        drive(4'h3, 1'b1, 1'b0, 48'd0); chk("R4 sum equal 3", count, 48'd1);
        drive(4'h8, 1'b1, 1'b0, 48'd0); chk("R4 sum 8 above 3", count, 48'd2);
        drive(4'hF, 1'b1, 1'b0, 48'd0); chk("R4 sum 15 adds one", count, 48'd3);
        cmask = 4'hF;
        drive(4'h7, 1'b1, 1'b0, 48'd0); chk("R4 sum 7 below 15", count, 48'd3);
        drive(4'hF, 1'b1, 1'b0, 48'd0); chk("R4 sum 15 meets 15", count, 48'd4);
    endtask

    task automatic t_and_pairs();
        logic [3:0] pairs [3] = '{4'h5, 4'h6, 4'hC};
        for (int p = 0; p < 3; p++) begin
            logic [47:0] exp = 0;
            umask = pairs[p]; cmask = pairs[p];
            drive(4'h0, 1'b0, 1'b1, 48'd0);
            for (int c = 0; c < 16; c++) begin
                drive(4'(c), 1'b1, 1'b0, 48'd0);
                if ((4'(c) & pairs[p]) == pairs[p]) exp++;
                chk("R5 AND pair counting", count, exp);
            end
        end
    endtask

    task automatic t_disable();
        umask = 4'hF; cmask = 4'h0;
        drive(4'h0, 1'b0, 1'b1, 48'd42);
        for (int k = 0; k < 4; k++) drive(4'hF, 1'b0, 1'b0, 48'd0);
        chk("R6 count held while disabled", count, 48'd42);
        chk("R6 ovf held while disabled", {47'd0, ovf}, 48'd0);
    endtask

    task automatic t_write();
        drive(4'h0, 1'b0, 1'b1, 48'h0000_8000_0000);
        chk("R7 load 2^31", count, 48'h0000_8000_0000);
        drive(4'h0, 1'b0, 1'b1, 48'hABCD_1234_5678);
        chk("R7 load full width", count, 48'hABCD_1234_5678);
        drive(4'h0, 1'b0, 1'b1, 48'd0);
        chk("R7 write zero clears", count, 48'd0);
        for (int k = 0; k < 3; k++) drive(4'hF, 1'b0, 1'b0, 48'd0);
        chk("R7 cleared value holds", count, 48'd0);
    endtask

    task automatic t_priority();
        umask = 4'hF; cmask = 4'h0;
        drive(4'hF, 1'b1, 1'b1, 48'd100);
        chk("R8 write wins over increment", count, 48'd100);
        drive(4'hF, 1'b1, 1'b0, 48'd0);
        chk("R8 counting resumes after write", count, 48'd115);
    endtask

    task automatic t_wrap();
        umask = 4'hF; cmask = 4'h0;
        drive(4'h0, 1'b0, 1'b1, 48'hFFFF_FFFF_FFFD);
        drive(4'hF, 1'b1, 1'b0, 48'd0);
        chk("R9 sum mode wraps", count, 48'd12);
        chk("R9 ovf set on wrap", {47'd0, ovf}, 48'd1);
        for (int k = 0; k < 3; k++) drive(4'h0, 1'b1, 1'b0, 48'd0);
        chk("R9 ovf sticky", {47'd0, ovf}, 48'd1);
        drive(4'h0, 1'b0, 1'b1, 48'hFFFF_FFFF_FFFF);
        chk("R10 write clears ovf", {47'd0, ovf}, 48'd0);
        cmask = 4'h1;
        drive(4'h1, 1'b1, 1'b0, 48'd0);
        chk("R9 threshold mode wraps", count, 48'd0);
        chk("R9 ovf set in threshold mode", {47'd0, ovf}, 48'd1);
    endtask

    task automatic t_ovf_clear();
        drive(4'h0, 1'b0, 1'b1, 48'd7);
        chk("R10 write loads value", count, 48'd7);
        chk("R10 ovf cleared by write", {47'd0, ovf}, 48'd0);
        drive(4'h0, 1'b1, 1'b0, 48'd0);
        chk("R10 ovf stays clear", {47'd0, ovf}, 48'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cond = 0; umask = 0; cmask = 0; en = 0; we = 0; wd = 0;
        @(negedge clk);
        t_reset();
        t_or_accum();
        t_masked();
        t_threshold();
        t_and_pairs();
        t_disable();
        t_write();
        t_priority();
        t_wrap();
        t_ovf_clear();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule